// File: doc/BRIEF.md
# Paged Pixel Palette Lookup Path

This block turns each incoming pixel into a 24-bit color. It forms an 8-bit palette address from the pixel and a page register, then reads the color from the pixel-side read port of an external palette RAM. It formats the color for a 6-bit or 8-bit DAC and delivers the red, green and blue words. The same formatted word also goes out on a test tap.

With fewer than eight bit-planes, the pixel fills only the low address bits. Each remaining upper address bit comes from the page register bit in the same position. Software can therefore recolour the whole screen by writing one register, without reloading the palette. In 6-bit mode each stored color is shifted up two places so the DAC sees a left-justified value. The plane mode and the width mode are sampled with each pixel and travel down the pipeline with it. The path is a two-stage pipeline: the palette RAM read, then the output formatting register.

Top module: `pal_lookup_path`

## Requirements
- R1: The page register resets to 0 and loads `page_wdata` on a clock edge where `page_we` is high. The first pixel sampled after that edge uses the new value.
- R2: The plane mode field `plane_mode` is encoded 00 = 1 plane, 01 = 2 planes, 10 = 4 planes, 11 = 8 planes. In 1-, 2- and 4-plane modes, the low 1, 2 or 4 bits of `ram_addr` equal the same bits of `pix_data`, and every higher address bit equals the page register bit in the same position.
- R3: In 8-plane mode, `ram_addr` equals `pix_data` and the page register has no effect.
- R4: `ram_addr` and `ram_rd` are driven combinationally in the cycle a pixel is presented. The RAM returns data one edge later. `out_valid` goes high exactly two clock edges after the edge that samples `pix_valid` high, and stays low two edges after an edge that samples it low.
- R5: In 8-bit mode (`narrow_mode` = 0), the output colors equal the RAM word unchanged: red from bits 23:16, green from 15:8, blue from 7:0.
- R6: In 6-bit mode (`narrow_mode` = 1), each output color is the stored color's six low bits moved to bits 7:2, with bits 1:0 forced to 0. The two stored upper bits are discarded.
- R7: `test_tap` carries the formatted word {red, green, blue}, taken after the 6-bit formatting.
- R8: While `out_valid` is low, the color outputs and `test_tap` hold their last values.
- R9: After reset, `out_valid` is low and all color outputs and `test_tap` are 0.
- R10: `plane_mode` and `narrow_mode` are sampled with each pixel. Changing them on every cycle gives each pixel its own addressing and formatting.
- R11: A pixel sampled on the same edge as a page write uses the old page value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_we | input | 1 | Page register write strobe |
| page_wdata | input | 8 | Page register write data |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 8 | Pixel value |
| plane_mode | input | 2 | Bit-plane mode, encoded as in R2 |
| narrow_mode | input | 1 | 1 selects 6-bit output formatting |
| ram_rd | output | 1 | Read enable to the palette RAM pixel port |
| ram_addr | output | 8 | Palette address |
| ram_rdata | input | 24 | Palette word, one cycle after the address |
| out_valid | output | 1 | Output colors valid |
| out_red | output | 8 | Red to the DAC |
| out_green | output | 8 | Green to the DAC |
| out_blue | output | 8 | Blue to the DAC |
| test_tap | output | 24 | Formatted {red, green, blue} for test |

## Verification
The assertions check these properties on every cycle:
- the page load;
- the pixel and page bit positions in 4-plane and 8-plane addressing;
- the two-edge valid latency;
- the zeroed low bits in 6-bit mode;
- the unchanged pass-through in 8-bit mode;
- the holding of the outputs when no pixel arrives.

Some behaviours only the bench scenarios can show. These are the timing of a page change relative to a pixel on the same edge, the recolouring across a sweep of all 16 pages, and each pixel keeping its own mode under per-cycle mode changes. All three rest on a reference model that computes the expected address and color independently.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        PLANES_1 = 2'b00,
        PLANES_2 = 2'b01,
        PLANES_4 = 2'b10,
        PLANES_8 = 2'b11
    } plane_mode_e;

    // number of low address bits taken from the pixel, capped at the address width
    function automatic int unsigned pixel_bits(input plane_mode_e m, input int unsigned aw);
        int unsigned n;
        n = 32'd1 << m;
        if (n > aw) n = aw;
        return n;
    endfunction

endpackage

// File: rtl/pal_page_reg.sv
module pal_page_reg #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] page
);

    always_ff @(posedge clk) begin
        if (!rst_n)  page <= '0;
        else if (we) page <= wdata;
    end

    assert_page_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (page == $past(wdata)));

    assert_page_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(page));

endmodule

// File: rtl/pal_addr_mux.sv
module pal_addr_mux
    import pal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  plane_mode_e       mode,
    input  logic [ADDR_W-1:0] pix,
    input  logic [ADDR_W-1:0] page,
    output logic [ADDR_W-1:0] addr
);

    int unsigned low_cnt;
    assign low_cnt = pixel_bits(mode, ADDR_W);

    // each address bit picks pixel or page bit in the same position
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign addr[i] = (i < low_cnt) ? pix[i] : page[i];
    end

endmodule

// File: rtl/pal_fmt.sv
module pal_fmt #(
    parameter int COLOR_W  = 8,
    parameter int NARROW_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld,
    input  logic                 narrow,
    input  logic [3*COLOR_W-1:0] cin,
    output logic [3*COLOR_W-1:0] cout
);

    localparam int SH = COLOR_W - NARROW_W;

    logic [3*COLOR_W-1:0] nxt;

    for (genvar ch = 0; ch < 3; ch++) begin : g_ch
        logic [COLOR_W-1:0] raw;
        assign raw = cin[ch*COLOR_W +: COLOR_W];
        assign nxt[ch*COLOR_W +: COLOR_W] = narrow ? (raw << SH) : raw;

        if (SH > 0) begin : g_chk
            assert_narrow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (ld && narrow) |=> (cout[ch*COLOR_W +: SH] == '0));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  cout <= '0;
        else if (ld) cout <= nxt;
    end

    assert_wide_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !narrow) |=> (cout == $past(cin)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(cout));

endmodule

// File: rtl/pal_lookup_path.sv
module pal_lookup_path
    import pal_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int COLOR_W  = 8,
    parameter int NARROW_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 page_we,
    input  logic [ADDR_W-1:0]    page_wdata,
    input  logic                 pix_valid,
    input  logic [ADDR_W-1:0]    pix_data,
    input  logic [1:0]           plane_mode,
    input  logic                 narrow_mode,
    output logic                 ram_rd,
    output logic [ADDR_W-1:0]    ram_addr,
    input  logic [3*COLOR_W-1:0] ram_rdata,
    output logic                 out_valid,
    output logic [COLOR_W-1:0]   out_red,
    output logic [COLOR_W-1:0]   out_green,
    output logic [COLOR_W-1:0]   out_blue,
    output logic [3*COLOR_W-1:0] test_tap
);

    localparam int WORD_W = 3 * COLOR_W;

    logic [ADDR_W-1:0] page_q;
    logic [ADDR_W-1:0] addr_w;
    logic              v_s1;
    logic              nar_s1;
    logic              v_s2;
    logic [WORD_W-1:0] color_q;

    pal_page_reg #(.ADDR_W(ADDR_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (page_we),
        .wdata (page_wdata),
        .page  (page_q)
    );

    pal_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
        .mode (plane_mode_e'(plane_mode)),
        .pix  (pix_data),
        .page (page_q),
        .addr (addr_w)
    );

    assign ram_rd   = pix_valid;
    assign ram_addr = addr_w;

    // stage 1: RAM read in flight, mode carried with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_s1   <= 1'b0;
            nar_s1 <= 1'b0;
            v_s2   <= 1'b0;
        end else begin
            v_s1 <= pix_valid;
            if (pix_valid) nar_s1 <= narrow_mode;
            v_s2 <= v_s1;
        end
    end

    // stage 2: output formatting
    pal_fmt #(.COLOR_W(COLOR_W), .NARROW_W(NARROW_W)) u_fmt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (v_s1),
        .narrow (nar_s1),
        .cin    (ram_rdata),
        .cout   (color_q)
    );

    assign out_valid = v_s2;
    assign out_red   = color_q[WORD_W-1 -: COLOR_W];
    assign out_green = color_q[2*COLOR_W-1 -: COLOR_W];
    assign out_blue  = color_q[COLOR_W-1:0];
    assign test_tap  = color_q;

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ##2 out_valid);

    assert_idle_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> ##2 !out_valid);

    assert_full_pixel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && plane_mode == 2'b11) |-> (ram_addr == pix_data));

    assert_page_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && plane_mode == 2'b10) |->
            (ram_addr[3:0] == pix_data[3:0] && ram_addr[ADDR_W-1:4] == page_q[ADDR_W-1:4]));

endmodule

// File: tb/sim_pal_lookup_path.sv
module sim_pal_lookup_path;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        page_we;
    logic [7:0]  page_wdata;
    logic        pix_valid;
    logic [7:0]  pix_data;
    logic [1:0]  plane_mode;
    logic        narrow_mode;
    logic        ram_rd;
    logic [7:0]  ram_addr;
    logic [23:0] ram_rdata = '0;
    logic        out_valid;
    logic [7:0]  out_red, out_green, out_blue;
    logic [23:0] test_tap;

    int total = 0;
    int fails = 0;
    bit done  = 0;
    string tag = "R9";

    always #(CLK_NS/2) clk = ~clk;

    pal_lookup_path u0 (
        .clk(clk), .rst_n(rst_n), .page_we(page_we), .page_wdata(page_wdata),
        .pix_valid(pix_valid), .pix_data(pix_data), .plane_mode(plane_mode),
        .narrow_mode(narrow_mode), .ram_rd(ram_rd), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .out_valid(out_valid), .out_red(out_red),
        .out_green(out_green), .out_blue(out_blue), .test_tap(test_tap)
    );

    function automatic logic [23:0] mem_val(input logic [7:0] a);
        return {a ^ 8'h5A, a + 8'd37, ~a ^ 8'h0F};
    endfunction

    // palette RAM pixel port: registered read
    always @(posedge clk) if (ram_rd) ram_rdata <= mem_val(ram_addr);

    function automatic logic [7:0] exp_addr(input logic [7:0] p, input logic [1:0] m, input logic [7:0] pg);
        int n;
        logic [7:0] mask;
        n = 1 << m;
        if (n >= 8) return p;
        mask = 8'((9'd1 << n) - 9'd1);
        return (p & mask) | (pg & ~mask);
    endfunction

    function automatic logic [23:0] fmt(input logic [23:0] c, input logic nar);
        if (!nar) return c;
        return {c[21:16], 2'b00, c[13:8], 2'b00, c[5:0], 2'b00};
    endfunction

    // behavioural reference model
    logic [7:0]  m_page;
    logic        m1_v, m_ov;
    logic [23:0] m1_c, m_oc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_page = '0; m1_v = 0; m_ov = 0; m1_c = '0; m_oc = '0;
        end else begin
            m_ov = m1_v;
            if (m1_v) m_oc = m1_c;
            m1_v = pix_valid;
            if (pix_valid) m1_c = fmt(mem_val(exp_addr(pix_data, plane_mode, m_page)), narrow_mode);
            if (page_we) m_page = page_wdata;
        end
    end

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(out_valid == m_ov, "R4 out_valid", 32'(out_valid), 32'(m_ov));
            chk({out_red, out_green, out_blue} == m_oc, m_ov ? tag : "R8",
                32'({out_red, out_green, out_blue}), 32'(m_oc));
            chk(test_tap == m_oc, "R7 test_tap", 32'(test_tap), 32'(m_oc));
            if (pix_valid)
                chk(ram_addr == exp_addr(pix_data, plane_mode, m_page),
                    (plane_mode == 2'b11) ? "R3 addr" : {tag, " addr"},
                    32'(ram_addr), 32'(exp_addr(pix_data, plane_mode, m_page)));
        end
    end

    task automatic px(input logic v, input logic [7:0] p, input logic [1:0] m,
                      input logic nar, input logic we, input logic [7:0] wd);
        @(negedge clk); #1;
        pix_valid = v; pix_data = p; plane_mode = m; narrow_mode = nar;
        page_we = we; page_wdata = wd;
    endtask

    initial begin
        rst_n = 0; page_we = 0; page_wdata = '0; pix_valid = 0;
        pix_data = '0; plane_mode = '0; narrow_mode = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(out_valid == 1'b0, "R9 valid", 32'(out_valid), 0);
        chk(test_tap == '0, "R9 tap", 32'(test_tap), 0);
        chk({out_red, out_green, out_blue} == '0, "R9 colors", 32'({out_red, out_green, out_blue}), 0);
        #1 rst_n = 1;

        tag = "R2";
        px(0, 0, 0, 0, 1, 8'hA5);
        for (int m = 0; m < 3; m++)
            for (int i = 0; i < 16; i++) px(1, 8'(i * 17), 2'(m), 0, 0, 0);

        tag = "R3";
        for (int i = 0; i < 21; i++) px(1, 8'(i * 13), 2'b11, 0, (i % 3) == 0, 8'(i * 29));

        tag = "R5";
        for (int i = 0; i < 40; i++) px(1, 8'(i * 7 + 3), 2'b11, 0, 0, 0);

        tag = "R6";
        for (int i = 0; i < 40; i++) px(1, 8'(i * 11), 2'(i % 4), 1, 0, 0);

        tag = "R8";
        for (int i = 0; i < 20; i++) px(i % 3 == 0, 8'(i * 31), 2'b11, i[0], 0, 0);
        for (int i = 0; i < 4; i++) px(0, 8'hFF, 2'b10, 1, 0, 0);

        tag = "R1";
        for (int p = 0; p < 16; p++) begin
            px(0, 8'h00, 2'b10, 0, 1, 8'(p << 4));
            px(1, 8'h07, 2'b10, 0, 0, 0);
        end

        tag = "R11";
        for (int i = 0; i < 12; i++) px(1, 8'(i * 5), 2'(i % 3), 0, 1, 8'(i * 53 + 1));

        tag = "R10";
        for (int i = 0; i < 48; i++) px(1, 8'(i * 7), 2'(i % 4), i[0] ^ i[2], i % 5 == 0, 8'(i * 19));

        for (int i = 0; i < 4; i++) px(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule